// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

This block receives bytes from an asynchronous serial line. It oversamples the line at sixteen times the bit rate, recognises a start bit, and gathers eight data bits least significant bit first. An even or odd parity bit may follow the data bits. One stop bit ends each frame. A good frame loads the byte into a data register, sets a ready flag and raises a one-cycle interrupt pulse. A DMA engine may answer that pulse with a read strobe, which clears the ready flag without any software write. Software reads a small status register and clears a flag by writing 0 to it, but only after it has seen that flag read back as 1.

Three sticky error flags record overrun, parity error and framing error. While any of them is set, the receiver stays idle and takes no new frames. A status bit always mirrors the synchronised line level, so a break can be recognised after a framing error. Dropping the enable input aborts any frame in progress and makes the receiver see an idle line.

The frame engine has five states. IDLE waits for a low sample on a tick and moves to START. START checks the line at mid-bit: a high level is a false start and returns to IDLE, a low level moves to DATA. DATA samples one bit at each full bit period. After the last data bit it moves to PARITY when parity is enabled, and to STOP otherwise. PARITY samples one bit and moves to STOP. STOP samples the stop bit, reports the frame and returns to IDLE. Deasserting enable forces IDLE from any state.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the status register (address 0) reads 8'h10 with the line idle high, the data output reads 0, and irq is low.
- R2: A frame consists of a low start bit, 8 data bits LSB first, an optional parity bit and one high stop bit, each lasting 16 ticks of baud_tick. After a good frame the byte appears on dma_rdata and at address 1, and status bit 0 (ready) is set.
- R3: irq is a pulse exactly one clock wide, issued in the cycle a byte is loaded into the data register with ready set.
- R4: Writing status bit n as 0 clears flag n (bits 0..3) only if a status read since the flag was last cleared returned it as 1. Writing a 1 leaves the flag unchanged.
- R5: A dma_rd pulse clears ready. During the pulse, dma_rdata holds the received byte.
- R6: If ready is still set when a stop bit is sampled, overrun (status bit 1) is set, the data register keeps its old byte, and no irq is issued. A dma_rd in the same cycle as the stop-bit sample counts as clearing ready first: the new byte is loaded and no overrun is recorded.
- R7: With par_en high, the parity bit must make the number of ones across data and parity even (par_odd low) or odd (par_odd high). A mismatch sets parity error (status bit 2).
- R8: A stop bit sampled low sets framing error (status bit 3). Status bit 4 always shows the synchronised rxd level, so a held-low line reads 0 there.
- R9: While any of status bits 1..3 is set, no frame is accepted: ready, data and irq stay unchanged. Reception resumes once all three are cleared.
- R10: With rx_en low the receiver ignores rxd, returns to IDLE, and produces no frame.
- R11: A low pulse shorter than half a bit is rejected at the mid-start sample and produces no frame and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low aborts and ignores the line |
| baud_tick | input | 1 | Strobe at 16 times the bit rate |
| rxd | input | 1 | Serial data line |
| par_en | input | 1 | Expect a parity bit after the data bits |
| par_odd | input | 1 | Select odd parity (1) or even parity (0) |
| reg_rd | input | 1 | Register read strobe; a read of address 0 arms flag clears |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects data |
| reg_wdata | input | 8 | Write data; 0 bits clear armed flags |
| reg_rdata | output | 8 | Read data for the addressed register |
| dma_rd | input | 1 | DMA read strobe; clears ready |
| dma_rdata | output | 8 | Received byte for the DMA engine |
| irq | output | 1 | One-cycle pulse when a new byte is loaded |

## Verification
The clash that matters is a DMA read of the old byte landing in the very cycle the next frame's stop bit is judged. The bench first measures, on a clean frame, the delay from the start-bit edge to the interrupt. It then places the read strobe exactly on the update edge of a second frame. The bench expects the old byte on the DMA output, the new byte loaded, ready set again, an interrupt, and no overrun. Moving the same strobe one cycle later must instead give an overrun, with the old byte kept.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    localparam int FLAG_N  = 4;
    localparam int B_READY = 0;
    localparam int B_OVR   = 1;
    localparam int B_PAR   = 2;
    localparam int B_FRM   = 3;
    localparam int B_LVL   = 4;

    localparam logic A_STATUS = 1'b0;
    localparam logic A_DATA   = 1'b1;
endpackage

// File: rtl/srx_line_sync.sv
`timescale 1ns/1ps
module srx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic rxd,
    output logic line_raw,
    output logic line
);
    logic [STAGES-1:0] sync_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= rxd;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign line_raw = sync_q[STAGES-1];
    // Disabled receiver sees an idle line.
    assign line     = rx_en ? line_raw : 1'b1;
endmodule

// File: rtl/srx_frame_fsm.sv
`timescale 1ns/1ps
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 hold,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 par_en,
    input  logic                 par_odd,
    output logic                 done,
    output logic [DATA_BITS-1:0] done_data,
    output logic                 done_perr,
    output logic                 done_ferr
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(DATA_BITS + 1);
    localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] TOP  = BW'(DATA_BITS - 1);

    rx_state_t            state, nxt;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        nbit;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bad;
    logic                 at_mid, at_full, par_exp;

    assign at_mid  = tick && (cnt == MID);
    assign at_full = tick && (cnt == LAST);
    assign par_exp = par_odd ? ~(^shreg) : (^shreg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!hold && !done && tick && !line) nxt = ST_START;
            ST_START:  if (at_mid) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_full && nbit == TOP) nxt = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_full) nxt = ST_STOP;
            ST_STOP:   if (at_full) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!rx_en) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            nbit      <= '0;
            shreg     <= '0;
            par_bad   <= 1'b0;
            done      <= 1'b0;
            done_data <= '0;
            done_perr <= 1'b0;
            done_ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (nxt != state)  cnt <= '0;
            else if (tick)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (state == ST_IDLE) begin
                nbit    <= '0;
                par_bad <= 1'b0;
            end
            if (state == ST_DATA && at_full) begin
                shreg <= {line, shreg[DATA_BITS-1:1]};
                nbit  <= nbit + 1'b1;
            end
            if (state == ST_PARITY && at_full) par_bad <= (line != par_exp);
            if (state == ST_STOP && at_full && rx_en) begin
                done      <= 1'b1;
                done_data <= shreg;
                done_perr <= par_bad;
                done_ferr <= ~line;
            end
        end
    end

    a_r9_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && state == ST_IDLE) |=> state == ST_IDLE);
    a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == ST_IDLE);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && at_mid && line) |=> (state == ST_IDLE && !done));
endmodule

// File: rtl/srx_status_regs.sv
`timescale 1ns/1ps
module srx_status_regs
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] done_data,
    input  logic                 done_perr,
    input  logic                 done_ferr,
    input  logic                 line_raw,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [DATA_BITS-1:0] reg_wdata,
    input  logic                 dma_rd,
    output logic [DATA_BITS-1:0] reg_rdata,
    output logic [DATA_BITS-1:0] dma_rdata,
    output logic                 irq,
    output logic                 hold
);
    logic [FLAG_N-1:0]    flag_q, armed_q, set_v, clr_v;
    logic [DATA_BITS-1:0] data_q, status_v;
    logic                 rd_stat, wr_stat, ready_eff, ovr, load_ok;
    logic                 unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_BITS-1:FLAG_N];
    assign rd_stat = reg_rd && reg_addr == A_STATUS;
    assign wr_stat = reg_wr && reg_addr == A_STATUS;

    always_comb begin
        clr_v = wr_stat ? (~reg_wdata[FLAG_N-1:0] & armed_q) : '0;
        clr_v[B_READY] = clr_v[B_READY] | dma_rd;
    end

    // A clear arriving with the stop sample takes effect first.
    assign ready_eff = flag_q[B_READY] & ~clr_v[B_READY];
    assign ovr       = done & ready_eff;
    assign load_ok   = done & ~ovr & ~done_perr & ~done_ferr;

    always_comb begin
        set_v          = '0;
        set_v[B_READY] = load_ok;
        set_v[B_OVR]   = ovr;
        set_v[B_PAR]   = done & done_perr;
        set_v[B_FRM]   = done & done_ferr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= '0;
            armed_q <= '0;
            data_q  <= '0;
            irq     <= 1'b0;
        end else begin
            flag_q  <= set_v | (flag_q & ~clr_v);
            armed_q <= (rd_stat ? (armed_q | flag_q) : armed_q) & ~clr_v & ~set_v;
            if (done && !ovr) data_q <= done_data;
            irq <= load_ok;
        end
    end

    always_comb begin
        status_v = '0;
        status_v[FLAG_N-1:0] = flag_q;
        status_v[B_LVL]      = line_raw;
    end

    assign reg_rdata = (reg_addr == A_DATA) ? data_q : status_v;
    assign dma_rdata = data_q;
    assign hold      = |flag_q[B_FRM:B_OVR];

    a_r3_irq_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q[B_READY]);
    a_r6_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[B_OVR]) |-> $stable(data_q));
    a_r5_dma_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && !done) |=> !flag_q[B_READY]);
    a_r4_write_one_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && &reg_wdata[FLAG_N-1:0] && !done && !dma_rd) |=> flag_q == $past(flag_q));
endmodule

// File: rtl/serial_rx_core.sv
`timescale 1ns/1ps
module serial_rx_core #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 baud_tick,
    input  logic                 rxd,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [DATA_BITS-1:0] reg_wdata,
    output logic [DATA_BITS-1:0] reg_rdata,
    input  logic                 dma_rd,
    output logic [DATA_BITS-1:0] dma_rdata,
    output logic                 irq
);
    logic                 line_raw, line, hold;
    logic                 done, done_perr, done_ferr;
    logic [DATA_BITS-1:0] done_data;

    srx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd),
        .line_raw(line_raw), .line(line)
    );

    srx_frame_fsm #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .hold(hold), .tick(baud_tick),
        .line(line), .par_en(par_en), .par_odd(par_odd),
        .done(done), .done_data(done_data), .done_perr(done_perr), .done_ferr(done_ferr)
    );

    srx_status_regs #(.DATA_BITS(DATA_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .done(done), .done_data(done_data),
        .done_perr(done_perr), .done_ferr(done_ferr), .line_raw(line_raw),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .dma_rd(dma_rd), .reg_rdata(reg_rdata), .dma_rdata(dma_rdata),
        .irq(irq), .hold(hold)
    );
endmodule

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       baud_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dma_rd = 1'b0;
    logic [7:0] dma_rdata;
    logic       irq;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   start_cyc = 0;
    int   lat = 0;
    logic irq_prev = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] st;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_tick(baud_tick), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_rd(dma_rd), .dma_rdata(dma_rdata), .irq(irq)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every interrupt must match the next queued byte.
    always @(negedge clk) begin
        #1;
        if (rst_n && irq) begin
            chk(!irq_prev, "R3 irq wider than one cycle", 1, 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected irq", dma_rdata, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(dma_rdata == e, "R2 received byte", dma_rdata, e);
                if (lat == 0) lat = cyc - start_cyc;
            end
        end
        irq_prev = irq;
    end

    task automatic put_bit(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic stop_v, input logic push);
        if (push) exp_q.push_back(d);
        start_cyc = cyc;
        put_bit(1'b0);
        for (int i = 0; i < 8; i++) put_bit(d[i]);
        if (par_en) put_bit((par_odd ? ~(^d) : (^d)) ^ bad_par);
        put_bit(stop_v);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic rd_stat(output logic [7:0] v);
        reg_addr = 1'b0; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        reg_addr = 1'b0; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic dma_pulse();
        dma_rd = 1'b1;
        @(negedge clk); dma_rd = 1'b0;
    endtask

    task automatic clear_all();
        rd_stat(st);
        wr_stat(8'h00);
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        rd_stat(st);
        chk(st == 8'h10, "R1 status after reset", st, 8'h10);
        chk(dma_rdata == 8'h00 && irq == 1'b0, "R1 data/irq after reset", dma_rdata, 0);

        // R2 plain frame, also measures the interrupt latency
        send(8'hA5, 1'b0, 1'b1, 1'b1);
        reg_addr = 1'b1; #1;
        chk(reg_rdata == 8'hA5, "R2 data register", reg_rdata, 8'hA5);
        @(negedge clk);

        // R4 clear rules
        wr_stat(8'h00);
        rd_stat(st);
        chk(st[0] == 1'b1, "R4 write 0 without prior read ignored", st, 8'h11);
        wr_stat(8'hFF);
        rd_stat(st);
        chk(st[0] == 1'b1, "R4 write 1 ignored", st, 8'h11);
        wr_stat(8'hFE);
        rd_stat(st);
        chk(st == 8'h10, "R4 armed write 0 clears ready", st, 8'h10);

        // R5 DMA clear
        send(8'h3C, 1'b0, 1'b1, 1'b1);
        dma_rd = 1'b1; #1;
        chk(dma_rdata == 8'h3C, "R5 dma data", dma_rdata, 8'h3C);
        @(negedge clk); dma_rd = 1'b0;
        rd_stat(st);
        chk(st == 8'h10, "R5 dma clears ready", st, 8'h10);

        // R7 parity
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h81, 1'b0, 1'b1, 1'b1);
        dma_pulse();
        par_odd = 1'b1;
        send(8'h7F, 1'b0, 1'b1, 1'b1);
        dma_pulse();
        rd_stat(st);
        chk(st == 8'h10, "R7 good parity no error", st, 8'h10);
        send(8'h55, 1'b1, 1'b1, 1'b0);
        rd_stat(st);
        chk(st == 8'h14, "R7 parity error flagged", st, 8'h14);

        // R9 freeze while an error is pending
        send(8'h66, 1'b0, 1'b1, 1'b0);
        rd_stat(st);
        chk(st == 8'h14, "R9 frame ignored while error set", st, 8'h14);
        wr_stat(8'h00);
        rd_stat(st);
        chk(st == 8'h10, "R9 error cleared", st, 8'h10);
        send(8'h99, 1'b0, 1'b1, 1'b1);
        chk(dma_rdata == 8'h99, "R9 reception resumed", dma_rdata, 8'h99);
        dma_pulse();
        par_en = 1'b0;

        // R8 framing error and break level
        send(8'h0F, 1'b0, 1'b0, 1'b0);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rd_stat(st);
        chk(st == 8'h08, "R8 framing error with line low", st, 8'h08);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        rd_stat(st);
        chk(st == 8'h18, "R8 line level follows rxd", st, 8'h18);
        wr_stat(8'h00);
        rd_stat(st);
        chk(st == 8'h10, "R8 framing error cleared", st, 8'h10);

        // R6 DMA read in the stop-sample update cycle
        send(8'h11, 1'b0, 1'b1, 1'b1);
        fork
            send(8'h22, 1'b0, 1'b1, 1'b1);
            begin
                @(negedge clk);
                while (cyc != start_cyc + lat - 1) @(negedge clk);
                dma_rd = 1'b1; #1;
                chk(dma_rdata == 8'h11, "R6 dma sees old byte at clash", dma_rdata, 8'h11);
                @(negedge clk); dma_rd = 1'b0;
            end
        join
        rd_stat(st);
        chk(st == 8'h11, "R6 clash: no overrun, ready set", st, 8'h11);
        chk(dma_rdata == 8'h22, "R6 clash: new byte loaded", dma_rdata, 8'h22);
        dma_pulse();

        // R6 DMA read one cycle too late
        send(8'h33, 1'b0, 1'b1, 1'b1);
        fork
            send(8'h44, 1'b0, 1'b1, 1'b0);
            begin
                @(negedge clk);
                while (cyc != start_cyc + lat) @(negedge clk);
                dma_rd = 1'b1;
                @(negedge clk); dma_rd = 1'b0;
            end
        join
        rd_stat(st);
        chk(st == 8'h12, "R6 late read gives overrun", st, 8'h12);
        chk(dma_rdata == 8'h33, "R6 overrun keeps old byte", dma_rdata, 8'h33);
        wr_stat(8'hFD);
        rd_stat(st);
        chk(st == 8'h10, "R6 overrun cleared", st, 8'h10);

        // R10 disabled receiver
        rx_en = 1'b0;
        send(8'h77, 1'b0, 1'b1, 1'b0);
        rd_stat(st);
        chk(st == 8'h10, "R10 no frame while disabled", st, 8'h10);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R11 short glitch
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        rd_stat(st);
        chk(st == 8'h10, "R11 glitch rejected", st, 8'h10);
        send(8'hC3, 1'b0, 1'b1, 1'b1);
        chk(dma_rdata == 8'hC3, "R11 frame after glitch", dma_rdata, 8'hC3);

        chk(exp_q.size() == 0, "R3 all expected irqs seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule